// File: doc/BRIEF.md
# Daisy-Chain Dual-Converter Write Controller

This block is the host-side master that writes new codes into a chain of dual-channel 12-bit converters. All converters in the chain share one serial clock and one active-low chip select. Each converter's serial output feeds the serial input of the next one. The controller takes one channel-A code and one channel-B code for every device. It packs them into a single frame of 24 bits per device and shifts that frame out in SPI mode 0, with the clock idle low. Every phase of the transfer is timed in system-clock cycles taken from parameters.

The word for the device at the far end of the chain goes out first. After N×24 clocks, each word therefore sits in the device it belongs to. Bits returning from the end of the chain are captured on every rising serial-clock edge. Those bits are the contents of the chain before the transfer, which is the frame written the time before.

The converters update their outputs in one of two ways, chosen per frame:
- In the three-wire arrangement, the rising edge of chip select loads the new codes into every device.
- In the four-wire arrangement, a separate active-low load strobe is pulsed after chip select has risen.

A busy flag covers the whole sequence, including the minimum chip-select high time. A one-cycle done pulse marks its end.

Top module: `dac_chain_writer`

## Requirements
- R1: The frame is N words of 24 bits, sent MSB first. The word for device N-1 (farthest from the controller) goes first and device 0's word goes last. Inside each word, the 12-bit channel-B code comes before the 12-bit channel-A code. Device d's codes are `code_b[d*12 +: 12]` and `code_a[d*12 +: 12]`.
- R2: `mosi` only changes while `sclk` is low. It holds steady across every cycle in which `sclk` is high.
- R3: Inside a frame, every `sclk` high phase and every `sclk` low phase between two rising edges lasts exactly HALF_DIV system clocks.
- R4: The first rising edge of `sclk` comes CSS_CYC system clocks after `cs_n` falls. `cs_n` rises CSH_CYC system clocks after the last falling edge of `sclk`.
- R5: `cs_n` falls exactly once per frame and stays low for all N×24 rising edges of `sclk`. `sclk` is low whenever `cs_n` is high.
- R6: When `mode4` is 1 at the start of a frame, `ldac_n` falls LDS_CYC system clocks after `cs_n` rises and stays low for LDW_CYC system clocks. `ldac_n` is only ever low while `cs_n` is high. When `mode4` is 0, `ldac_n` stays high.
- R7: Between frames, `cs_n` stays high for at least CSW_CYC system clocks, even when `start` is held ready.
- R8: `busy` goes high in the cycle after `start` is accepted and stays high until `done`. A `start` seen while `busy` is high starts no frame.
- R9: `done` is a single-cycle pulse, given in the cycle in which `busy` falls.
- R10: `rdback` holds the N×24 bits sampled from `miso` at each rising `sclk` edge, with the first bit received in the MSB. It updates when `cs_n` rises, so after a frame it equals the previous frame.
- R11: After reset, `cs_n`=1, `sclk`=0, `ldac_n`=1, `mosi`=0, `busy`=0, `done`=0 and `rdback`=0. A reset in the middle of a frame returns these outputs to that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a frame; taken only when not busy |
| mode4 | input | 1 | 1: pulse load strobe after chip select; 0: chip-select rise loads |
| code_b | input | NUM_DEV*CODE_W | Channel-B codes, device d at slice d |
| code_a | input | NUM_DEV*CODE_W | Channel-A codes, device d at slice d |
| miso | input | 1 | Serial data returning from the end of the chain |
| busy | output | 1 | A frame or its recovery gap is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Shared active-low chip select |
| mosi | output | 1 | Serial data into device 0 |
| ldac_n | output | 1 | Active-low load strobe (four-wire use) |
| rdback | output | NUM_DEV*2*CODE_W | Bits read back during the last frame |

## Verification
The bench builds the controller with three devices and the default timing counts for a 50 MHz system clock, which gives 72-bit frames. An odd chain length with three distinct device words exposes any reversal of the word order or of the channel order, which a two-device build with mirrored codes could hide. A behavioural chain of shift registers and latches in the bench receives the frames. Back-to-back frames then bring the read-back path, the chip-select gap and both load arrangements within reach, including a load strobe that must not latch on the chip-select edge.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HI,
    ST_LO,
    ST_HOLD,
    ST_LDWAIT,
    ST_LDPULSE,
    ST_RECOV
  } dcw_state_t;
endpackage

// File: rtl/dcw_frame_pack.sv
module dcw_frame_pack #(
  parameter int NUM_DEV = 2,
  parameter int CODE_W  = 12
) (
  input  logic [NUM_DEV*CODE_W-1:0]   code_b,
  input  logic [NUM_DEV*CODE_W-1:0]   code_a,
  output logic [NUM_DEV*2*CODE_W-1:0] frame
);
  localparam int WORD_W = 2 * CODE_W;

  // Highest slice is shifted first, so device NUM_DEV-1 occupies the top word.
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_word
    assign frame[d*WORD_W +: WORD_W] = {code_b[d*CODE_W +: CODE_W],
                                        code_a[d*CODE_W +: CODE_W]};
  end
endmodule

// File: rtl/dcw_tx_shift.sv
module dcw_tx_shift #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         dout
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load) begin
      sr <= din;
    end else if (shift) begin
      sr <= {sr[W-2:0], 1'b0};
    end
  end

  assign dout = sr[W-1];
endmodule

// File: rtl/dcw_rx_capture.sv
module dcw_rx_capture #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample,
  input  logic         bit_in,
  input  logic         snap,
  output logic [W-1:0] held
);
  logic [W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      held <= '0;
    end else begin
      if (sample) acc <= {acc[W-2:0], bit_in};
      if (snap)   held <= acc;
    end
  end
endmodule

// File: rtl/dac_chain_writer.sv
module dac_chain_writer
  import dcw_pkg::*;
#(
  parameter int NUM_DEV  = 2,
  parameter int CODE_W   = 12,
  parameter int HALF_DIV = 4,
  parameter int CSS_CYC  = 3,
  parameter int CSH_CYC  = 4,
  parameter int LDS_CYC  = 3,
  parameter int LDW_CYC  = 5,
  parameter int CSW_CYC  = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        mode4,
  input  logic [NUM_DEV*CODE_W-1:0]   code_b,
  input  logic [NUM_DEV*CODE_W-1:0]   code_a,
  input  logic                        miso,
  output logic                        busy,
  output logic                        done,
  output logic                        sclk,
  output logic                        cs_n,
  output logic                        mosi,
  output logic                        ldac_n,
  output logic [NUM_DEV*2*CODE_W-1:0] rdback
);
  localparam int FRAME_W = NUM_DEV * 2 * CODE_W;
  localparam int EDGE_W  = $clog2(FRAME_W + 1);
  localparam int MAX_1   = (HALF_DIV > CSS_CYC) ? HALF_DIV : CSS_CYC;
  localparam int MAX_2   = (CSH_CYC > LDS_CYC) ? CSH_CYC : LDS_CYC;
  localparam int MAX_3   = (LDW_CYC > CSW_CYC) ? LDW_CYC : CSW_CYC;
  localparam int MAX_12  = (MAX_1 > MAX_2) ? MAX_1 : MAX_2;
  localparam int MAX_ALL = (MAX_12 > MAX_3) ? MAX_12 : MAX_3;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  dcw_state_t           state;
  logic [CNT_W-1:0]     cnt;
  logic [EDGE_W-1:0]    edges;
  logic                 mode4_q;
  logic [FRAME_W-1:0]   frame;
  int                   lim;
  logic                 tick;
  logic                 load, shift, sample, snap;

  dcw_frame_pack #(.NUM_DEV(NUM_DEV), .CODE_W(CODE_W)) u_pack (
    .code_b(code_b), .code_a(code_a), .frame(frame)
  );

  // Length of the current phase in system clocks.
  always_comb begin
    unique case (state)
      ST_SETUP:       lim = CSS_CYC;
      ST_HI, ST_LO:   lim = HALF_DIV;
      ST_HOLD:        lim = CSH_CYC;
      ST_LDWAIT:      lim = LDS_CYC;
      ST_LDPULSE:     lim = LDW_CYC;
      ST_RECOV:       lim = CSW_CYC;
      default:        lim = 1;
    endcase
  end

  assign tick   = (cnt == CNT_W'(lim - 1));
  assign load   = (state == ST_IDLE) && start;
  assign sample = tick && ((state == ST_SETUP) || (state == ST_LO));
  assign shift  = tick && (state == ST_HI) && (edges != EDGE_W'(FRAME_W));
  assign snap   = tick && (state == ST_HOLD);

  dcw_tx_shift #(.W(FRAME_W)) u_tx (
    .clk(clk), .rst(rst), .load(load), .shift(shift), .din(frame), .dout(mosi)
  );

  dcw_rx_capture #(.W(FRAME_W)) u_rx (
    .clk(clk), .rst(rst), .sample(sample), .bit_in(miso), .snap(snap),
    .held(rdback)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      edges   <= '0;
      mode4_q <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      ldac_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      if (state != ST_IDLE) cnt <= tick ? '0 : cnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) begin
            cs_n    <= 1'b0;
            busy    <= 1'b1;
            mode4_q <= mode4;
            edges   <= '0;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP, ST_LO: begin
          if (tick) begin
            sclk  <= 1'b1;
            edges <= edges + 1'b1;
            state <= ST_HI;
          end
        end
        ST_HI: begin
          if (tick) begin
            sclk  <= 1'b0;
            state <= (edges == EDGE_W'(FRAME_W)) ? ST_HOLD : ST_LO;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            cs_n  <= 1'b1;
            state <= mode4_q ? ST_LDWAIT : ST_RECOV;
          end
        end
        ST_LDWAIT: begin
          if (tick) begin
            ldac_n <= 1'b0;
            state  <= ST_LDPULSE;
          end
        end
        ST_LDPULSE: begin
          if (tick) begin
            ldac_n <= 1'b1;
            state  <= ST_RECOV;
          end
        end
        ST_RECOV: begin
          if (tick) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
  parameter int HALF_DIV = 4,
  parameter int LDW_CYC  = 5,
  parameter int CSW_CYC  = 6
) (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic ldac_n,
  input logic busy,
  input logic done
);
  logic [15:0] hi_len, ld_len, gap_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len  <= '0;
      ld_len  <= '0;
      gap_len <= 16'(CSW_CYC);
    end else begin
      hi_len  <= sclk ? hi_len + 1'b1 : '0;
      ld_len  <= !ldac_n ? ld_len + 1'b1 : '0;
      if (!cs_n)               gap_len <= '0;
      else if (gap_len != '1)  gap_len <= gap_len + 1'b1;
    end
  end

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_sclk_high_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_len == 16'(HALF_DIV)));

  p_ldac_in_gap_r6: assert property (@(posedge clk) disable iff (rst)
    !ldac_n |-> cs_n);

  p_ldac_width_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ldac_n) |-> (ld_len == 16'(LDW_CYC)));

  p_cs_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (gap_len >= 16'(CSW_CYC)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_busy_end_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind dac_chain_writer dcw_checker #(
  .HALF_DIV(HALF_DIV), .LDW_CYC(LDW_CYC), .CSW_CYC(CSW_CYC)
) u_dcw_checker (
  .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
  .ldac_n(ldac_n), .busy(busy), .done(done)
);

// File: tb/test_dac_chain_writer.sv
module test_dac_chain_writer;
  localparam int N     = 3;
  localparam int CW    = 12;
  localparam int TOT   = N * 2 * CW;
  localparam int HALF  = 4;
  localparam int CSS   = 3;
  localparam int CSH   = 4;
  localparam int LDS   = 3;
  localparam int LDW   = 5;
  localparam int CSW   = 6;
  localparam int VEC_W = 1 + 2 * N * CW;

  // {mode4, code_b (dev2,dev1,dev0), code_a (dev2,dev1,dev0)}
  localparam logic [VEC_W-1:0] VECS [4] = '{
    {1'b0, 36'hFFF000A5A, 36'h123456789},
    {1'b1, 36'h8000017FF, 36'hFFFFFFFFF},
    {1'b0, 36'h000000000, 36'h000000000},
    {1'b1, 36'hABCDEF012, 36'h3456789AB}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode4 = 1'b0;
  logic [N*CW-1:0] code_b = '0, code_a = '0;
  logic miso, busy, done, sclk, cs_n, mosi, ldac_n;
  logic [TOT-1:0] rdback;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  dac_chain_writer #(
    .NUM_DEV(N), .CODE_W(CW), .HALF_DIV(HALF), .CSS_CYC(CSS), .CSH_CYC(CSH),
    .LDS_CYC(LDS), .LDW_CYC(LDW), .CSW_CYC(CSW)
  ) i_dac_chain_writer (
    .clk(clk), .rst(rst), .start(start), .mode4(mode4), .code_b(code_b),
    .code_a(code_a), .miso(miso), .busy(busy), .done(done), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .ldac_n(ldac_n), .rdback(rdback)
  );

  // Behavioural chain of converters.
  logic [23:0] dev_sr  [N];
  logic [23:0] dev_lat [N];
  logic        dev_do  [N];
  initial for (int d = 0; d < N; d++) begin
    dev_sr[d] = '0; dev_lat[d] = '0; dev_do[d] = 1'b0;
  end

  always @(posedge sclk) if (!cs_n)
    for (int d = 0; d < N; d++)
      dev_sr[d] <= {dev_sr[d][22:0], (d == 0) ? mosi : dev_do[d-1]};

  always @(negedge sclk or negedge cs_n)
    for (int d = 0; d < N; d++) dev_do[d] <= dev_sr[d][23];

  always @(posedge cs_n or negedge ldac_n)
    if (cs_n && !(mode4 ? ldac_n : 1'b0))
      for (int d = 0; d < N; d++) dev_lat[d] <= dev_sr[d];

  assign miso = dev_do[N-1];

  // Port monitor, sampled between edges.
  int cyc = 0, rises, csfalls, donecnt, ldfalls, hi_bad, lo_bad, mosi_bad;
  int hi_run = 0, lo_run = 0, t_csfall, t_first, t_lastfall, t_csrise = -1000;
  int t_ldfall, t_ldrise, last_gap = 1000;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_ld = 1'b1, p_mosi = 1'b0;

  always @(negedge clk) if (!rst) begin
    cyc++;
    if (p_cs && !cs_n) begin csfalls++; t_csfall = cyc; last_gap = cyc - t_csrise; end
    if (!p_cs && cs_n) t_csrise = cyc;
    if (sclk && !p_sclk) begin
      if (rises == 0) t_first = cyc;
      else if (lo_run != HALF) lo_bad++;
      rises++; hi_run = 0;
    end
    if (!sclk && p_sclk) begin
      if (hi_run != HALF) hi_bad++;
      t_lastfall = cyc; lo_run = 0;
    end
    if (sclk) hi_run++;
    else if (!cs_n) lo_run++;
    if (sclk && p_sclk && (mosi != p_mosi)) mosi_bad++;
    if (p_ld && !ldac_n) begin ldfalls++; t_ldfall = cyc; end
    if (!p_ld && ldac_n) t_ldrise = cyc;
    if (done) donecnt++;
    p_sclk = sclk; p_cs = cs_n; p_ld = ldac_n; p_mosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TOT-1:0] frame_of(input logic [N*CW-1:0] b,
                                              input logic [N*CW-1:0] a);
    logic [TOT-1:0] f;
    for (int d = 0; d < N; d++) f[d*24 +: 24] = {b[d*CW +: CW], a[d*CW +: CW]};
    return f;
  endfunction

  logic [TOT-1:0] prev_frame = '0;

  task automatic run_frame(input logic [VEC_W-1:0] v, input bit check_gap);
    logic [TOT-1:0] exp_f, got;
    int waited;
    @(negedge clk);
    mode4  = v[VEC_W-1];
    code_b = v[2*N*CW-1 -: N*CW];
    code_a = v[N*CW-1:0];
    rises = 0; csfalls = 0; donecnt = 0; ldfalls = 0;
    hi_bad = 0; lo_bad = 0; mosi_bad = 0;
    exp_f = frame_of(code_b, code_a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    repeat (20) @(negedge clk);
    start = 1'b1;                     // R8: must be ignored while busy
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 5000) begin @(negedge clk); waited++; end
    chk(waited < 5000, "R9 done seen", waited, 0);
    @(negedge clk);
    got = '0;
    for (int d = 0; d < N; d++) got[d*24 +: 24] = dev_lat[d];
    chk(got == exp_f, "R1 latched words", got, exp_f);
    chk(rises == TOT, "R5 sclk rising edges", rises, TOT);
    chk(csfalls == 1, "R5 R8 single cs fall", csfalls, 1);
    chk(hi_bad == 0 && lo_bad == 0, "R3 phase widths", hi_bad + lo_bad, 0);
    chk(mosi_bad == 0, "R2 mosi stable high", mosi_bad, 0);
    chk(t_first - t_csfall == CSS, "R4 cs setup", t_first - t_csfall, CSS);
    chk(t_csrise - t_lastfall == CSH, "R4 cs hold", t_csrise - t_lastfall, CSH);
    if (mode4) begin
      chk(ldfalls == 1, "R6 one load pulse", ldfalls, 1);
      chk(t_ldfall - t_csrise == LDS, "R6 load delay", t_ldfall - t_csrise, LDS);
      chk(t_ldrise - t_ldfall == LDW, "R6 load width", t_ldrise - t_ldfall, LDW);
    end else begin
      chk(ldfalls == 0, "R6 no load pulse in 3-wire", ldfalls, 0);
    end
    chk(rdback == prev_frame, "R10 read-back", rdback, prev_frame);
    chk(donecnt == 1, "R9 done pulse count", donecnt, 1);
    if (check_gap) chk(last_gap >= CSW, "R7 cs high gap", last_gap, CSW);
    prev_frame = exp_f;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(cs_n == 1 && sclk == 0 && ldac_n == 1 && mosi == 0,
        "R11 reset pins", {cs_n, sclk, ldac_n, mosi}, 4'b1010);
    chk(busy == 0 && done == 0 && rdback == '0, "R11 reset status",
        {busy, done, rdback}, 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) run_frame(VECS[i], i > 0);
    // R11: reset in the middle of a frame
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && ldac_n == 1 && busy == 0 && rdback == '0,
        "R11 mid-frame reset", {cs_n, sclk, ldac_n, busy}, 4'b1010);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule